// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master of a shared single-wire bus. The bus carries both power and data to one or more slaves. The line is open-drain with a resistor pullup, so the block can only pull it low (through `lineOe`) or let it go. It reads the line back through a two-flop synchronizer. Every bit travels in a time slot that the master starts, and the bit value is coded as the width of the low pulse. A long reset pulse comes before any traffic, and attached slaves answer it with a low presence pulse.

A host starts one operation with a one-cycle `start` and a command code. The operations are: reset with a presence check, write one bit, read one bit, write a byte and read a byte. Bytes travel least significant bit first as eight slots. To read a byte, the block sends eight write-1 slots, which leaves each slave free to hold the line low for a 0. Two speed grades are available, standard and overdrive. The grade is taken from `overdrive` when the command is accepted. All durations are cycle counts derived from the clock frequency parameter. The cycle counts below are for the default of 50 MHz.

Top module: `swm_master`

## Requirements
- R1: After reset, `lineOe`, `busy`, `done` and `presence` are 0 and `dataOut` is 0.
- R2: Command 0 (bus reset) holds `lineOe` high for exactly 24000 cycles at standard speed or 3500 at overdrive. `busy` stays high for 48000 or 7000 cycles in total, and `done` then pulses.
- R3: After a bus reset, `presence` is 1 if the line was low at the presence sampling point and 0 otherwise. The sampling point is 3500 cycles after release at standard speed and 425 at overdrive.
- R4: Command 1 writes `dataIn[0]`. A 0 gives a low pulse of 3000 cycles (standard) or 375 (overdrive). A 1 gives 300 or 50. The slot, including recovery, keeps `busy` high for 3750 or 600 cycles.
- R5: Command 2 reads one bit. It uses a 300 or 50 cycle low pulse and samples the line 750 or 100 cycles into the slot. The result is in `dataOut[0]`, and bits 7..1 are 0.
- R6: Command 3 writes `dataIn` as eight slots, LSB first. Each slot's low width follows R4 for its bit, and `busy` lasts eight slot times.
- R7: Command 4 reads a byte as eight narrow-pulse slots. `dataOut` holds the sampled bits, with the first slot in bit 0.
- R8: The speed grade is latched when a command is accepted. Changing `overdrive` while `busy` does not change any width or duration.
- R9: A `start` while `busy` is ignored. Codes 5 to 7 are ignored: `busy` and `lineOe` stay 0.
- R10: `lineOe` is only ever 1 while `busy`. `done` is a single-cycle pulse with `busy` low.
- R11: After write commands, `dataOut` holds the line level sampled in each slot. With no slave pulling, this equals the written data (one bit in bit 0 for command 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command strobe |
| cmd | input | 3 | Command code (0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte) |
| dataIn | input | 8 | Data to write |
| overdrive | input | 1 | 1 selects overdrive speed, sampled at start |
| lineIn | input | 1 | Bus line level (asynchronous) |
| lineOe | output | 1 | 1 pulls the bus line low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |
| dataOut | output | 8 | Read or readback data |
| presence | output | 1 | Presence result of the last bus reset |

## Verification
A wrong slot or reset counter shows up at once as a wrong low-pulse width on `lineOe`, or as a wrong `busy` duration. The scoreboard measures the first in cycles on every pulse and the second on every command. A bad shift register or bit index shows up as a wrong `dataOut` at the `done` pulse that ends the byte. Writing an asymmetric byte catches bit-order errors, because they change the sequence of pulse widths. A wrong sampling point or synchronizer shows up as a flipped `presence` or read bit, because the slave model holds the line low only for a bounded window around the correct sampling point.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic [2:0] {
    CMD_RESET  = 3'd0,
    CMD_WBIT   = 3'd1,
    CMD_RBIT   = 3'd2,
    CMD_WBYTE  = 3'd3,
    CMD_RBYTE  = 3'd4
  } swmCmd_e;

  typedef struct packed {
    logic cntClr;
    logic shLoad;
    logic loadOnes;
    logic loadBit;
    logic rxSample;
    logic shShift;
    logic presSample;
    logic outLatch;
    logic outByte;
    logic drvLow;
  } swmStrb_t;

  // nanoseconds to clock cycles, rounded up
  function automatic int swmCycles(input int ns, input int clkMhz);
    return (ns * clkMhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/swm_datapath.sv
module swm_datapath
  import swm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  swmStrb_t          strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lineIn,
  output logic [CNT_W-1:0]  cnt,
  output logic              txBit,
  output logic              lineOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              presence
);

  logic              syncA, syncB;
  logic              rxBit;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shNext;

  assign shNext = {rxBit, shReg[DATA_W-1:1]};
  assign txBit  = shReg[0];
  assign lineOe = strb.drvLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      rxBit    <= 1'b1;
      dataOut  <= '0;
      presence <= 1'b0;
    end else begin
      if (strb.shLoad) begin
        if (strb.loadOnes)     shReg <= '1;
        else if (strb.loadBit) shReg <= {{(DATA_W-1){1'b1}}, dataIn[0]};
        else                   shReg <= dataIn;
      end else if (strb.shShift) begin
        shReg <= shNext;
      end
      if (strb.rxSample)   rxBit    <= syncB;
      if (strb.presSample) presence <= ~syncB;
      if (strb.outLatch)
        dataOut <= strb.outByte ? shNext : {{(DATA_W-1){1'b0}}, rxBit};
    end
  end

  // R3: presence is sampled only with the line released
  a_r3_pres_released: assert property (@(posedge clk) disable iff (!rstN)
    strb.presSample |-> !lineOe);

  // R4: a 1 bit has released the line by its sampling point
  a_r4_one_released: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxSample && txBit) |-> !lineOe);

endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
  import swm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int CLK_MHZ = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       cmd,
  input  logic             overdrive,
  input  logic [CNT_W-1:0] cnt,
  input  logic             txBit,
  output swmStrb_t         strb,
  output logic             busy,
  output logic             done
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  localparam logic [CNT_W-1:0] S_RST_LOW = CNT_W'(swmCycles(480000, CLK_MHZ));
  localparam logic [CNT_W-1:0] S_PRES_AT = CNT_W'(swmCycles(550000, CLK_MHZ));
  localparam logic [CNT_W-1:0] S_RST_END = CNT_W'(swmCycles(960000, CLK_MHZ) - 1);
  localparam logic [CNT_W-1:0] S_LOW0    = CNT_W'(swmCycles(60000, CLK_MHZ));
  localparam logic [CNT_W-1:0] S_LOW1    = CNT_W'(swmCycles(6000, CLK_MHZ));
  localparam logic [CNT_W-1:0] S_SAMP    = CNT_W'(swmCycles(15000, CLK_MHZ));
  localparam logic [CNT_W-1:0] S_SLOTEND = CNT_W'(swmCycles(75000, CLK_MHZ) - 1);
  localparam logic [CNT_W-1:0] O_RST_LOW = CNT_W'(swmCycles(70000, CLK_MHZ));
  localparam logic [CNT_W-1:0] O_PRES_AT = CNT_W'(swmCycles(78500, CLK_MHZ));
  localparam logic [CNT_W-1:0] O_RST_END = CNT_W'(swmCycles(140000, CLK_MHZ) - 1);
  localparam logic [CNT_W-1:0] O_LOW0    = CNT_W'(swmCycles(7500, CLK_MHZ));
  localparam logic [CNT_W-1:0] O_LOW1    = CNT_W'(swmCycles(1000, CLK_MHZ));
  localparam logic [CNT_W-1:0] O_SAMP    = CNT_W'(swmCycles(2000, CLK_MHZ));
  localparam logic [CNT_W-1:0] O_SLOTEND = CNT_W'(swmCycles(12000, CLK_MHZ) - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RESET, ST_SLOT} state_e;

  state_e           state;
  logic             odReg;
  logic             byteOp;
  logic [IDX_W-1:0] bitIdx;
  logic             accept;
  logic             lastBit;
  logic [CNT_W-1:0] tRstLow, tPresAt, tRstEnd, tLow0, tLow1, tSamp, tSlotEnd;

  assign tRstLow  = odReg ? O_RST_LOW : S_RST_LOW;
  assign tPresAt  = odReg ? O_PRES_AT : S_PRES_AT;
  assign tRstEnd  = odReg ? O_RST_END : S_RST_END;
  assign tLow0    = odReg ? O_LOW0    : S_LOW0;
  assign tLow1    = odReg ? O_LOW1    : S_LOW1;
  assign tSamp    = odReg ? O_SAMP    : S_SAMP;
  assign tSlotEnd = odReg ? O_SLOTEND : S_SLOTEND;

  assign busy    = (state != ST_IDLE);
  assign accept  = (state == ST_IDLE) && start && (cmd <= CMD_RBYTE);
  assign lastBit = byteOp ? (bitIdx == LAST_IDX) : 1'b1;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        strb.cntClr = 1'b1;
        if (accept) begin
          strb.shLoad   = 1'b1;
          strb.loadOnes = (cmd == CMD_RBIT) || (cmd == CMD_RBYTE);
          strb.loadBit  = (cmd == CMD_WBIT);
        end
      end
      ST_RESET: begin
        strb.drvLow     = (cnt < tRstLow);
        strb.presSample = (cnt == tPresAt);
      end
      ST_SLOT: begin
        strb.drvLow   = (cnt < (txBit ? tLow1 : tLow0));
        strb.rxSample = (cnt == tSamp);
        if (cnt == tSlotEnd) begin
          strb.cntClr   = 1'b1;
          strb.shShift  = 1'b1;
          strb.outLatch = lastBit;
          strb.outByte  = byteOp;
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      odReg  <= 1'b0;
      byteOp <= 1'b0;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= (cmd == CMD_RESET) ? ST_RESET : ST_SLOT;
          odReg  <= overdrive;
          byteOp <= (cmd == CMD_WBYTE) || (cmd == CMD_RBYTE);
          bitIdx <= '0;
        end
        ST_RESET: if (cnt == tRstEnd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        ST_SLOT: if (cnt == tSlotEnd) begin
          if (lastBit) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: the line is only pulled during a command
  a_r10_oe_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.drvLow |-> busy);

  // R10: done lasts one cycle and never overlaps busy
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));

  // R8: speed grade cannot change inside a command
  a_r8_speed_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(odReg));

endmodule

// File: rtl/swm_master.sv
module swm_master
  import swm_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              overdrive,
  input  logic              lineIn,
  output logic              lineOe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] dataOut,
  output logic              presence
);

  localparam int CNT_W = $clog2(swmCycles(960000, CLK_MHZ) + 1);

  swmStrb_t         strb;
  logic [CNT_W-1:0] cnt;
  logic             txBit;

  swm_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .overdrive(overdrive),
    .cnt(cnt), .txBit(txBit), .strb(strb), .busy(busy), .done(done)
  );

  swm_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .lineIn(lineIn),
    .cnt(cnt), .txBit(txBit), .lineOe(lineOe), .dataOut(dataOut),
    .presence(presence)
  );

endmodule

// File: tb/swm_master_bench.sv
module swm_master_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] dataIn = 8'd0;
  logic       overdrive = 1'b0;
  logic       lineIn;
  logic       lineOe, busy, done, presence;
  logic [7:0] dataOut;

  logic slvLowA = 1'b0, slvLowP = 1'b0;
  bit   slvActive = 1'b0;
  logic [7:0] slvBits = 8'hFF;
  int   slvHold = 200;
  bit   presEn = 1'b0;
  int   presDly = 50, presLen = 950;

  int checks = 0, errors = 0;
  int expW[$];
  int expR[$];
  int expKind[$];   // 1 = presence, 0 = dataOut
  int doneCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign lineIn = !(lineOe || slvLowA || slvLowP);

  swm_master u_swm_master (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .dataIn(dataIn),
    .overdrive(overdrive), .lineIn(lineIn), .lineOe(lineOe), .busy(busy),
    .done(done), .dataOut(dataOut), .presence(presence)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: low pulse widths
  int runLen = 0;
  always @(negedge clk) begin
    if (lineOe) runLen++;
    else if (runLen > 0) begin
      if (expW.size() == 0) chk(0, "R9 unexpected pulse", runLen, 0);
      else begin
        int w;
        w = expW.pop_front();
        chk(runLen == w, "R2/R4/R6/R8 low width", runLen, w);
      end
      runLen = 0;
    end
  end

  // monitor: results at done
  always @(negedge clk) begin
    if (done) begin
      doneCount++;
      if (expR.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        int v, k;
        v = expR.pop_front();
        k = expKind.pop_front();
        if (k == 1) chk(presence == v[0], "R3 presence", int'(presence), v);
        else        chk(int'(dataOut) == v, "R5/R7/R11 dataOut", int'(dataOut), v);
      end
      chk(!busy, "R10 done with busy low", int'(busy), 0);
    end
  end

  // slave: answers read slots with 0 by holding the line
  initial begin
    logic prevOe;
    prevOe = 1'b0;
    forever begin
      @(negedge clk);
      if (lineOe && !prevOe && slvActive) begin
        logic b;
        b = slvBits[0];
        slvBits = {slvBits[0], slvBits[7:1]};
        if (!b) begin
          slvLowA = 1'b1;
          repeat (slvHold) @(negedge clk);
          slvLowA = 1'b0;
        end
      end
      prevOe = lineOe;
    end
  end

  // slave: presence pulse after a long low
  initial begin
    int run;
    run = 0;
    forever begin
      @(negedge clk);
      if (lineOe) run++;
      else begin
        if (run > 3200 && presEn) begin
          repeat (presDly) @(negedge clk);
          slvLowP = 1'b1;
          repeat (presLen) @(negedge clk);
          slvLowP = 1'b0;
        end
        run = 0;
      end
    end
  end

  task automatic setSpeed(input bit od);
    slvHold = od ? 200 : 1500;
    presDly = od ? 50 : 300;
    presLen = od ? 950 : 5700;
  endtask

  // driver: issues a command, flips overdrive during it (R8), checks busy length
  task automatic doCmd(input logic [2:0] c, input logic [7:0] d, input bit od,
                       input int busyExp, input bit poke, input string req);
    int n;
    @(negedge clk);
    cmd = c; dataIn = d; overdrive = od; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    overdrive = ~od;
    n = 1;
    while (busy) begin
      @(negedge clk);
      if (poke && n == 100) begin start = 1'b1; cmd = 3'd0; overdrive = od; end
      else start = 1'b0;
      if (busy) n++;
    end
    start = 1'b0;
    chk(n == busyExp, req, n, busyExp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lineOe == 1'b0, "R1 lineOe", int'(lineOe), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(presence == 1'b0, "R1 presence", int'(presence), 0);
    chk(dataOut == 8'd0, "R1 dataOut", int'(dataOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: overdrive reset with and without presence
    setSpeed(1); presEn = 1;
    expW.push_back(3500); expR.push_back(1); expKind.push_back(1);
    doCmd(3'd0, 8'h00, 1, 7000, 0, "R2 od reset busy");
    presEn = 0;
    expW.push_back(3500); expR.push_back(0); expKind.push_back(1);
    doCmd(3'd0, 8'h00, 1, 7000, 0, "R3 od reset no presence busy");

    // R4 R11: single-bit writes
    expW.push_back(375); expR.push_back(0); expKind.push_back(0);
    doCmd(3'd1, 8'hFE, 1, 600, 0, "R4 od write0 busy");
    expW.push_back(50); expR.push_back(1); expKind.push_back(0);
    doCmd(3'd1, 8'h01, 1, 600, 0, "R4 od write1 busy");

    // R5: single-bit reads
    slvActive = 1; slvBits = 8'h00;
    expW.push_back(50); expR.push_back(0); expKind.push_back(0);
    doCmd(3'd2, 8'h00, 1, 600, 0, "R5 od read0 busy");
    slvBits = 8'hFF;
    expW.push_back(50); expR.push_back(1); expKind.push_back(0);
    doCmd(3'd2, 8'h00, 1, 600, 0, "R5 od read1 busy");
    slvActive = 0;

    // R6 R11: byte write 0xA5, LSB first
    for (int i = 0; i < 8; i++) expW.push_back(((8'hA5 >> i) & 1) ? 50 : 375);
    expR.push_back(8'hA5); expKind.push_back(0);
    doCmd(3'd3, 8'hA5, 1, 4800, 0, "R6 od write byte busy");

    // R7: byte read 0x3C
    slvActive = 1; slvBits = 8'h3C;
    for (int i = 0; i < 8; i++) expW.push_back(50);
    expR.push_back(8'h3C); expKind.push_back(0);
    doCmd(3'd4, 8'h00, 1, 4800, 0, "R7 od read byte busy");
    slvActive = 0;

    // R9: start during busy is ignored
    expW.push_back(50); expR.push_back(1); expKind.push_back(0);
    doCmd(3'd1, 8'h01, 1, 600, 1, "R9 busy start ignored busy");
    repeat (50) @(negedge clk);
    chk(expW.size() == 0 && !busy, "R9 no extra activity", expW.size(), 0);
    chk(doneCount == 9, "R9 done count", doneCount, 9);

    // R9: undefined command code ignored
    begin
      int bad;
      bad = 0;
      @(negedge clk); cmd = 3'd5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (busy || lineOe) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R9 code 5 ignored", bad, 0);
    end

    // R2 R3 R8: standard reset, overdrive flipped mid-command
    setSpeed(0); presEn = 1;
    expW.push_back(24000); expR.push_back(1); expKind.push_back(1);
    doCmd(3'd0, 8'h00, 0, 48000, 0, "R2 std reset busy");
    presEn = 0;

    // R4 R8: standard write 0
    expW.push_back(3000); expR.push_back(0); expKind.push_back(0);
    doCmd(3'd1, 8'h00, 0, 3750, 0, "R4 std write0 busy");

    // R5: standard read returning 0
    slvActive = 1; slvBits = 8'h00;
    expW.push_back(300); expR.push_back(0); expKind.push_back(0);
    doCmd(3'd2, 8'h00, 0, 3750, 0, "R5 std read0 busy");
    slvActive = 0;

    repeat (20) @(negedge clk);
    chk(expW.size() == 0 && expR.size() == 0, "R10 scoreboard drained",
        expW.size() + expR.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule